// File: doc/BRIEF.md
# AES-128 Round Key Sequencer

This block supplies the round keys of an AES-128 encryption datapath one at a time, computing each from the one before it so that no expanded key schedule has to be stored. A load strobe captures a 128-bit cipher key, which is presented at once as the round-0 key. Each step strobe then replaces the presented key with the next one and advances a 4-bit round counter, up to round 10.

Each step works on the key's four 32-bit columns. Column 0 sits in bits [127:96] and column 3 in bits [31:0]. Within a column, the most significant byte is the top row.

The last column is rotated and substituted through four S-box instances, and a round constant is mixed into its top byte. The result is then chained through the columns from left to right. The round constant is kept in its own small register and is doubled in GF(2^8) on every step.

Top module: `aes_kg_top`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it falls with no strobe, `rkey_o` is all zeros and `round_o` is 0.
- R2: A load strobe makes `rkey_o` equal `key_i` and `round_o` equal 0 one cycle later. Load takes priority over a simultaneous step.
- R3: A step strobe without load, while `round_o` is below 10, increments `round_o` by one and presents the next round key one cycle later.
- R4: The word used to build the next key takes the bytes of column 3 in the order (row1, row2, row3, row0) and passes each of them through the AES S-box.
- R5: The round constant is XORed only into the top byte of that word. It is 01 for round 1 and is doubled modulo x^8+x^4+x^3+x+1 for each later round, so round 9 uses 1B and round 10 uses 36.
- R6: New column 0 is the modified word XOR old column 0. Each new column k, for k = 1, 2, 3, is old column k XOR new column k-1.
- R7: A step strobe while `round_o` is 10 leaves `rkey_o` and `round_o` unchanged.
- R8: With neither strobe asserted, `rkey_o` and `round_o` hold their values.
- R9: For the cipher key 000102030405060708090A0B0C0D0E0F, round 1 starts with column D6AA74FD, and round 10 is 13111D7FE3944A17F307A78B4D2B30C5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load strobe: capture `key_i` as round 0 |
| key_i | input | 128 | Cipher key, column 0 in the top bits |
| step_i | input | 1 | Step strobe: advance to the next round key |
| rkey_o | output | 128 | Current round key |
| round_o | output | 4 | Index of the current round key, 0 to 10 |

## Verification
The hardest state to reach from the ports is the end of the schedule. There, a step must be ignored while the round constant would otherwise wrap past 36. Getting there takes a full load followed by ten steps.

The stimulus therefore runs complete schedules for several keys, then issues extra steps at round 10. It also reloads partway through a schedule, which confirms that the round constant restarts at 01. A load asserted together with a step is applied as well, to check that load wins.

// File: rtl/aes_kg_pkg.sv
package aes_kg_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int NUM_COLS   = 4;
    localparam int KEY_W      = WORD_W * NUM_COLS;
    localparam int LAST_ROUND = 10;
    localparam int RND_W      = $clog2(LAST_ROUND + 1);

    localparam logic [BYTE_W-1:0] RCON_FIRST = 8'h01;
    localparam logic [BYTE_W-1:0] GF_POLY    = 8'h1B;
    localparam logic [BYTE_W-1:0] AFF_CONST  = 8'h63;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [RND_W-1:0]  rnd_t;

    // Column 0 occupies the most significant word.
    typedef struct packed {
        word_t c0;
        word_t c1;
        word_t c2;
        word_t c3;
    } rkey_t;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_LOAD,
        OP_STEP,
        OP_HOLD
    } op_e;

    // Multiply by x modulo the field polynomial.
    function automatic byte_t xtime(input byte_t a);
        byte_t r;
        r = {a[BYTE_W-2:0], 1'b0};
        if (a[BYTE_W-1]) r = r ^ GF_POLY;
        return r;
    endfunction

    // General product in GF(2^8).
    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254; zero maps to zero.
    function automatic byte_t gf_inv(input byte_t a);
        byte_t sq;
        byte_t prod;
        sq   = a;
        prod = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            sq   = gf_mul(sq, sq);
            prod = gf_mul(prod, sq);
        end
        return prod;
    endfunction

    function automatic byte_t rotl8(input byte_t a, input int n);
        byte_t r;
        r = a;
        for (int i = 0; i < n; i++) r = {r[BYTE_W-2:0], r[BYTE_W-1]};
        return r;
    endfunction

    // Affine output stage of the substitution.
    function automatic byte_t sbox_affine(input byte_t a);
        return a ^ rotl8(a, 1) ^ rotl8(a, 2) ^ rotl8(a, 3) ^ rotl8(a, 4) ^ AFF_CONST;
    endfunction

    // Rotate a column one byte toward the top row.
    function automatic word_t rot_word(input word_t w);
        return {w[WORD_W-BYTE_W-1:0], w[WORD_W-1 -: BYTE_W]};
    endfunction

endpackage

// File: rtl/aes_kg_sbox.sv
module aes_kg_sbox
    import aes_kg_pkg::*;
(
    input  logic [7:0] in_b,
    output logic [7:0] out_b
);
    byte_t inv_b;

    always_comb begin
        inv_b = gf_inv(in_b);
        out_b = sbox_affine(inv_b);
    end
endmodule

// File: rtl/aes_kg_rcon.sv
module aes_kg_rcon
    import aes_kg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       advance,
    output logic [7:0] rcon
);
    byte_t rcon_q;

    always_ff @(posedge clk) begin
        if (rst || restart) rcon_q <= RCON_FIRST;
        else if (advance)   rcon_q <= xtime(rcon_q);
    end

    assign rcon = rcon_q;
endmodule

// File: rtl/aes_kg_expand.sv
module aes_kg_expand
    import aes_kg_pkg::*;
(
    input  logic [127:0] cur_key,
    input  logic [7:0]   rcon,
    output logic [127:0] nxt_key
);
    rkey_t cur;
    rkey_t nxt;
    word_t rot_w;
    word_t sub_w;
    word_t mix_w;

    assign cur   = rkey_t'(cur_key);
    assign rot_w = rot_word(cur.c3);

    genvar g;
    generate
        for (g = 0; g < WORD_BYTES; g++) begin : g_sub
            aes_kg_sbox u_sb (
                .in_b  (rot_w[BYTE_W*g +: BYTE_W]),
                .out_b (sub_w[BYTE_W*g +: BYTE_W])
            );
        end
    endgenerate

    assign mix_w = sub_w ^ {rcon, {(WORD_W-BYTE_W){1'b0}}};

    always_comb begin
        nxt.c0 = cur.c0 ^ mix_w;
        nxt.c1 = cur.c1 ^ nxt.c0;
        nxt.c2 = cur.c2 ^ nxt.c1;
        nxt.c3 = cur.c3 ^ nxt.c2;
    end

    assign nxt_key = nxt;
endmodule

// File: rtl/aes_kg_top.sv
module aes_kg_top
    import aes_kg_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [127:0] key_i,
    input  logic         step_i,
    output logic [127:0] rkey_o,
    output logic [3:0]   round_o
);
    op_e   op;
    rkey_t key_q;
    rnd_t  rnd_q;
    byte_t rcon;
    logic [KEY_W-1:0] nxt_key;

    always_comb begin
        if (load_i)                          op = OP_LOAD;
        else if (step_i && rnd_q < LAST_ROUND) op = OP_STEP;
        else if (step_i)                     op = OP_HOLD;
        else                                 op = OP_IDLE;
    end

    aes_kg_rcon u_rcon (
        .clk     (clk),
        .rst     (rst),
        .restart (op == OP_LOAD),
        .advance (op == OP_STEP),
        .rcon    (rcon)
    );

    aes_kg_expand u_exp (
        .cur_key (key_q),
        .rcon    (rcon),
        .nxt_key (nxt_key)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
            rnd_q <= '0;
        end else begin
            case (op)
                OP_LOAD: begin
                    key_q <= rkey_t'(key_i);
                    rnd_q <= '0;
                end
                OP_STEP: begin
                    key_q <= rkey_t'(nxt_key);
                    rnd_q <= rnd_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign rkey_o  = key_q;
    assign round_o = rnd_q;
endmodule

// File: rtl/aes_kg_checker.sv
module aes_kg_checker (
    input logic         clk,
    input logic         rst,
    input logic         load_i,
    input logic [127:0] key_i,
    input logic         step_i,
    input logic [127:0] rkey_o,
    input logic [3:0]   round_o
);
    AST_LOAD_ROUND: assert property (@(posedge clk) disable iff (rst)
        load_i |=> round_o == 4'd0); // R2
    AST_LOAD_KEY: assert property (@(posedge clk) disable iff (rst)
        load_i |=> rkey_o == $past(key_i)); // R2
    AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && round_o < 4'd10) |=> round_o == $past(round_o) + 4'd1); // R3
    AST_ROUND_RANGE: assert property (@(posedge clk) disable iff (rst)
        round_o <= 4'd10); // R3
    AST_CHAIN_C1: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && round_o < 4'd10) |=>
        (rkey_o[95:64] ^ rkey_o[127:96]) == $past(rkey_o[95:64])); // R6
    AST_CHAIN_C3: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && round_o < 4'd10) |=>
        (rkey_o[31:0] ^ rkey_o[63:32]) == $past(rkey_o[31:0])); // R6
    AST_END_HOLD: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i && round_o == 4'd10) |=> $stable(rkey_o) && $stable(round_o)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !load_i) |=> $stable(rkey_o) && $stable(round_o)); // R8
endmodule

bind aes_kg_top aes_kg_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_i),
    .key_i   (key_i),
    .step_i  (step_i),
    .rkey_o  (rkey_o),
    .round_o (round_o)
);

// File: tb/tb_aes_kg_top.sv
module tb_aes_kg_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_i = 1'b0;
    logic         step_i = 1'b0;
    logic [127:0] key_i = '0;
    logic [127:0] rkey_o;
    logic [3:0]   round_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [127:0] k;
        logic [3:0]   r;
        string        tag;
    } exp_t;
    exp_t sb_q[$];

    logic [127:0] m_key = '0;
    int           m_rnd = 0;

    always #5 clk = ~clk;

    aes_kg_top dut (
        .clk(clk), .rst(rst), .load_i(load_i), .key_i(key_i),
        .step_i(step_i), .rkey_o(rkey_o), .round_o(round_o)
    );

    // Reference arithmetic, written independently of the design.
    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] m_sbox(input logic [7:0] x);
        logic [7:0] inv = 8'h00;
        logic [7:0] y;
        for (int c = 1; c < 256; c++) if (m_mul(x, 8'(c)) == 8'h01) inv = 8'(c);
        for (int i = 0; i < 8; i++)
            y[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8];
        return y ^ 8'h63;
    endfunction

    function automatic logic [7:0] m_rc(input int rnd);
        case (rnd)
            1: return 8'h01;  2: return 8'h02;  3: return 8'h04;  4: return 8'h08;
            5: return 8'h10;  6: return 8'h20;  7: return 8'h40;  8: return 8'h80;
            9: return 8'h1B; 10: return 8'h36;
            default: return 8'h00;
        endcase
    endfunction

    // R4, R5, R6 reference step
    function automatic logic [127:0] m_next(input logic [127:0] k, input int rnd);
        logic [31:0] w [4];
        logic [31:0] t;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        t = {m_sbox(w[3][23:16]), m_sbox(w[3][15:8]), m_sbox(w[3][7:0]), m_sbox(w[3][31:24])};
        t[31:24] = t[31:24] ^ m_rc(rnd);
        w[0] = w[0] ^ t;
        for (int i = 1; i < 4; i++) w[i] = w[i] ^ w[i-1];
        return {w[0], w[1], w[2], w[3]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic apply(input bit ld, input bit st, input logic [127:0] k, input string tag);
        exp_t e;
        @(negedge clk);
        load_i = ld; step_i = st; key_i = k;
        @(posedge clk);
        #1;
        if (ld) begin
            m_key = k; m_rnd = 0;
        end else if (st && m_rnd < 10) begin
            m_rnd = m_rnd + 1;
            m_key = m_next(m_key, m_rnd);
        end
        e.k = m_key; e.r = 4'(m_rnd); e.tag = tag;
        sb_q.push_back(e);
        load_i = 1'b0; step_i = 1'b0;
    endtask

    // Monitor: compare away from the active edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(rkey_o == e.k, {e.tag, " key"}, rkey_o, e.k);
            chk(round_o == e.r, {e.tag, " round"}, 128'(round_o), 128'(e.r));
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    localparam logic [127:0] K_SEQ = 128'h000102030405060708090A0B0C0D0E0F;
    localparam logic [127:0] K_ALT = 128'h2B7E151628AED2A6ABF7158809CF4F3C;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(rkey_o == '0 && round_o == 4'd0, "R1 in reset", rkey_o, '0);
        @(negedge clk); rst = 1'b0;
        apply(0, 0, '0, "R1 after reset");
        apply(1, 0, K_SEQ, "R2 load");
        apply(0, 1, '0, "R3 R4 R5 R6 step 1");
        chk(rkey_o[127:96] == 32'hD6AA74FD, "R9 round1 column0", 128'(rkey_o[127:96]), 128'(32'hD6AA74FD));
        for (int i = 2; i <= 10; i++) apply(0, 1, '0, "R3 R5 R6 step");
        chk(rkey_o == 128'h13111D7FE3944A17F307A78B4D2B30C5, "R9 round10", rkey_o,
            128'h13111D7FE3944A17F307A78B4D2B30C5);
        apply(0, 1, '0, "R7 step at end");
        apply(0, 1, '0, "R7 step at end again");
        apply(0, 0, '0, "R8 idle");
        apply(1, 1, '0, "R2 load beats step");
        apply(0, 1, '0, "R4 zero key step");
        chk(rkey_o == {4{32'h62636363}}, "R4 R5 zero key round1", rkey_o, {4{32'h62636363}});
        apply(0, 1, '0, "R3 zero key step 2");
        apply(0, 0, '0, "R8 idle mid");
        apply(1, 0, K_ALT, "R2 reload mid schedule");
        for (int i = 1; i <= 10; i++) apply(0, 1, '0, "R3 R5 alt key step");
        apply(0, 1, '0, "R7 alt key end");
        apply(1, 0, ~K_ALT, "R2 load inverted");
        for (int i = 1; i <= 4; i++) apply(0, 1, '0, "R6 inverted key step");
        apply(0, 0, '0, "R8 final idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule